// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C controller from three programmable timing words, counting cycles of one fixed reference clock. It sets how long SCL is held low and how long it is released. Within each phase it marks the cycle where the data sequencer may change SDA (the launch point, in the low phase) and the cycle where it should sample SDA (the sample point, in the high phase). It also times the hold after a START, the setup before a STOP and the idle gap that must follow a STOP before the bus counts as free again.

A sequencer pulses `cmd_start` while the bus is free. The generator then runs low and high phases in turn until `cmd_stop` has been seen. After the high phase in which the stop is pending, it adds one more low phase, then a released setup phase that ends with the stop strobe, and then the bus-free interval. Each programmed phase count is extended by a fixed number of cycles. When SCL clock stretching detection is enabled, a target that keeps SCL low while the generator has released it freezes the high phase count.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is asserted and after reset, with no command given, `bus_free` is 1, `scl_oe` is 0 and every strobe and `stretching` are 0.
- R2: Count fields are 10 bits at bit 16 (upper half) and bit 0 (lower half) of each 32-bit word. `cfg_high_word` holds the high count (upper) and the sample offset (lower). `cfg_low_word` holds the low count and the launch offset. `cfg_bus_word` holds the bus-free count (upper) and the lead-in count (lower). Bits 31:26 and 15:10 of every word are ignored.
- R3: `cmd_start` is accepted only while `bus_free` is 1. In the cycle after the accepting edge, `start_stb` is 1. SCL stays released for max(lead-in, 1) cycles, counting that cycle.
- R4: A low phase drives `scl_oe` to 1 for low count + 2 cycles. `fall_stb` is 1 in its first cycle. `launch_stb` is 1 in the cycle whose 0-based index equals the launch offset, and never if the offset is not below the phase length.
- R5: A high phase releases SCL for high count + 7 counted cycles. `rise_stb` is 1 in the first counted cycle. `sample_stb` is 1 in the counted cycle whose index equals the sample offset, and never if the offset is not below the phase length.
- R6: After the lead-in, low and high phases alternate, each starting its count from zero, until a stop takes effect.
- R7: A `cmd_stop` seen during the lead-in, a low phase or a high phase is held. It takes effect at the end of the next high phase. It causes one more low phase (with fall and launch strobes), then a released setup phase of high count + 7 cycles. That phase has `rise_stb` in its first cycle and `stop_stb` in its last cycle.
- R8: After the setup phase, `bus_free` stays 0 for max(bus-free count, 1) cycles, with SCL released. It then returns to 1.
- R9: With `stretch_en` at 1 and `scl_in` at 0 during a high or setup phase, the phase count does not advance, `stretching` is 1 and no strobe fires. With `stretch_en` at 0, `scl_in` has no effect.
- R10: `cmd_start` while the bus is busy and `cmd_stop` while the bus is free have no effect on the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_high_word | input | 32 | High count and sample offset |
| cfg_low_word | input | 32 | Low count and launch offset |
| cfg_bus_word | input | 32 | Bus-free count and lead-in count |
| cmd_start | input | 1 | Begin a transfer (START) |
| cmd_stop | input | 1 | Finish the transfer with a STOP |
| stretch_en | input | 1 | Enable clock stretching detection |
| scl_in | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| start_stb | output | 1 | SDA may fall to form START |
| fall_stb | output | 1 | First cycle of a low phase |
| launch_stb | output | 1 | SDA may change |
| rise_stb | output | 1 | First counted cycle of a released phase |
| sample_stb | output | 1 | Sample SDA now |
| stop_stb | output | 1 | SDA may rise to form STOP |
| stretching | output | 1 | High phase held by a stretching target |
| bus_free | output | 1 | Bus idle, bus-free interval elapsed |

## Verification
Every output is decoded from registered phase state, so a strobe shows in the very cycle its 0-based index names. The first lead-in cycle is the one after the edge that accepts `cmd_start`. The bench builds the expected phase sequence from the programmed counts and steps through it one cycle at a time. In each cycle it drives the inputs just after the falling edge and compares all outputs one time unit later. Stretch cycles are inserted in front of the counted high cycles, because a held phase adds cycles without moving its index.

// File: rtl/i2c_scl_timer_pkg.sv
package i2c_scl_timer_pkg;

  parameter int unsigned CNT_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_SLOW  = 3'd4,
    ST_SETUP = 3'd5,
    ST_BFREE = 3'd6
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] high_cnt;
    logic [CNT_W-1:0] rx_off;
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] tx_off;
    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] lead_cnt;
  } tcfg_t;

endpackage

// File: rtl/i2c_scl_timer_unpack.sv
module i2c_scl_timer_unpack
  import i2c_scl_timer_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] bus_word,
  output tcfg_t             cfg
);

  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned PAD_W  = HALF_W - CNT_W;

  // upper half of each word carries the phase length, lower half the offset
  assign cfg.high_cnt = hi_word[HALF_W +: CNT_W];
  assign cfg.rx_off   = hi_word[0 +: CNT_W];
  assign cfg.low_cnt  = lo_word[HALF_W +: CNT_W];
  assign cfg.tx_off   = lo_word[0 +: CNT_W];
  assign cfg.free_cnt = bus_word[HALF_W +: CNT_W];
  assign cfg.lead_cnt = bus_word[0 +: CNT_W];

  // padding bits above each field are don't-care (R2)
  logic unused_pad;
  assign unused_pad = ^{hi_word[WORD_W-1 -: PAD_W], hi_word[HALF_W-1 -: PAD_W],
                        lo_word[WORD_W-1 -: PAD_W], lo_word[HALF_W-1 -: PAD_W],
                        bus_word[WORD_W-1 -: PAD_W], bus_word[HALF_W-1 -: PAD_W]};

endmodule

// File: rtl/i2c_scl_timer_count.sv
module i2c_scl_timer_count #(
  parameter int unsigned PH_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            adv,
  input  logic [PH_W-1:0] len,
  output logic [PH_W-1:0] cnt,
  output logic            last
);

  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = restart || adv;
    cnt_d  = restart ? '0 : cnt_q + PH_W'(1);
    // >= keeps the phase bounded if the length shrinks mid-phase
    last   = adv && (cnt_q >= (len - PH_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  a_r6_restart_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_scl_timer_ctrl.sv
module i2c_scl_timer_ctrl
  import i2c_scl_timer_pkg::*;
#(
  parameter int unsigned LOW_EXTRA  = 2,
  parameter int unsigned HIGH_EXTRA = 7,
  parameter int unsigned PH_W       = CNT_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tcfg_t           cfg,
  input  logic            cmd_start,
  input  logic            cmd_stop,
  input  logic            stretch_en,
  input  logic            scl_in,
  input  logic [PH_W-1:0] cnt,
  input  logic            last,
  output logic [PH_W-1:0] len,
  output logic            restart,
  output logic            adv,
  output logic            scl_oe,
  output logic            start_stb,
  output logic            fall_stb,
  output logic            launch_stb,
  output logic            rise_stb,
  output logic            sample_stb,
  output logic            stop_stb,
  output logic            stretching,
  output logic            bus_free
);

  phase_e state_q, state_d;
  logic   stop_q, stop_d;
  logic   in_low, in_high;

  function automatic logic [PH_W-1:0] min_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? PH_W'(1) : PH_W'(v);
  endfunction

  always_comb begin
    in_low  = (state_q == ST_LOW) || (state_q == ST_SLOW);
    in_high = (state_q == ST_HIGH) || (state_q == ST_SETUP);
  end

  // phase length, including the fixed cycles added to each SCL phase
  always_comb begin
    case (state_q)
      ST_HOLD:           len = min_one(cfg.lead_cnt);
      ST_LOW, ST_SLOW:   len = PH_W'(cfg.low_cnt) + PH_W'(LOW_EXTRA);
      ST_HIGH, ST_SETUP: len = PH_W'(cfg.high_cnt) + PH_W'(HIGH_EXTRA);
      ST_BFREE:          len = min_one(cfg.free_cnt);
      default:           len = PH_W'(1);
    endcase
  end

  always_comb begin
    stretching = in_high && stretch_en && !scl_in;
    adv        = !stretching;
    restart    = (state_q == ST_IDLE) || last;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (cmd_start) state_d = ST_HOLD;
      ST_HOLD:  if (last) state_d = ST_LOW;
      ST_LOW:   if (last) state_d = ST_HIGH;
      ST_HIGH:  if (last) state_d = (stop_q || cmd_stop) ? ST_SLOW : ST_LOW;
      ST_SLOW:  if (last) state_d = ST_SETUP;
      ST_SETUP: if (last) state_d = ST_BFREE;
      ST_BFREE: if (last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_HOLD, ST_LOW: stop_d = stop_q || cmd_stop;
      ST_HIGH:         stop_d = last ? 1'b0 : (stop_q || cmd_stop);
      default:         stop_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
    end
  end

  always_comb begin
    scl_oe     = in_low;
    bus_free   = (state_q == ST_IDLE);
    start_stb  = (state_q == ST_HOLD) && (cnt == '0);
    fall_stb   = in_low && (cnt == '0);
    launch_stb = in_low && (cnt == PH_W'(cfg.tx_off));
    rise_stb   = in_high && adv && (cnt == '0);
    sample_stb = (state_q == ST_HIGH) && adv && (cnt == PH_W'(cfg.rx_off));
    stop_stb   = (state_q == ST_SETUP) && last;
  end

  a_r3_start_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && bus_free) |=> start_stb);
  a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !bus_free) |=> !start_stb);
  a_r4_launch_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> scl_oe);
  a_r5_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !scl_oe);
  a_r8_free_waits: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> !bus_free);
  a_r7_free_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> ($past(state_q) == ST_BFREE));
  a_r9_stretch_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    stretching |=> $stable(cnt));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_timer_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LOW_EXTRA  = 2,
  parameter int unsigned HIGH_EXTRA = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_high_word,
  input  logic [WORD_W-1:0] cfg_low_word,
  input  logic [WORD_W-1:0] cfg_bus_word,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              stretch_en,
  input  logic              scl_in,
  output logic              scl_oe,
  output logic              start_stb,
  output logic              fall_stb,
  output logic              launch_stb,
  output logic              rise_stb,
  output logic              sample_stb,
  output logic              stop_stb,
  output logic              stretching,
  output logic              bus_free
);

  localparam int unsigned PH_W = CNT_W + 1;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  tcfg_t           cfg;
  logic [PH_W-1:0] len;
  logic [PH_W-1:0] cnt;
  logic            restart;
  logic            adv;
  logic            last;

  i2c_scl_timer_unpack #(.WORD_W(WORD_W)) u_unpack (
    .hi_word  (cfg_high_word),
    .lo_word  (cfg_low_word),
    .bus_word (cfg_bus_word),
    .cfg      (cfg)
  );

  i2c_scl_timer_count #(.PH_W(PH_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_ni),
    .restart (restart),
    .adv     (adv),
    .len     (len),
    .cnt     (cnt),
    .last    (last)
  );

  i2c_scl_timer_ctrl #(
    .LOW_EXTRA  (LOW_EXTRA),
    .HIGH_EXTRA (HIGH_EXTRA),
    .PH_W       (PH_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_ni),
    .cfg        (cfg),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .stretch_en (stretch_en),
    .scl_in     (scl_in),
    .cnt        (cnt),
    .last       (last),
    .len        (len),
    .restart    (restart),
    .adv        (adv),
    .scl_oe     (scl_oe),
    .start_stb  (start_stb),
    .fall_stb   (fall_stb),
    .launch_stb (launch_stb),
    .rise_stb   (rise_stb),
    .sample_stb (sample_stb),
    .stop_stb   (stop_stb),
    .stretching (stretching),
    .bus_free   (bus_free)
  );

  a_r1_free_means_released: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_free |-> !scl_oe);

endmodule

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  typedef struct packed {
    logic [9:0] hi;
    logic [9:0] ro;
    logic [9:0] lo;
    logic [9:0] to;
    logic [9:0] lead;
    logic [9:0] bfree;
    logic [3:0] nbits;
    logic [3:0] st_cyc;
    logic       st_en;
    logic       junk;
    logic       busy_start;
    logic       idle_stop;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{10'd5, 10'd3,  10'd6, 10'd2, 10'd4, 10'd5, 4'd2, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{10'd1, 10'd0,  10'd1, 10'd0, 10'd0, 10'd0, 4'd1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{10'd3, 10'd12, 10'd4, 10'd9, 10'd2, 10'd3, 4'd2, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{10'd4, 10'd2,  10'd3, 10'd1, 10'd3, 10'd2, 4'd3, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{10'd4, 10'd1,  10'd3, 10'd1, 10'd2, 10'd2, 4'd2, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    '{10'd4, 10'd1,  10'd3, 10'd1, 10'd2, 10'd2, 4'd2, 4'd3, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_high_word, cfg_low_word, cfg_bus_word;
  logic        cmd_start, cmd_stop, stretch_en, scl_in;
  logic        scl_oe, start_stb, fall_stb, launch_stb, rise_stb;
  logic        sample_stb, stop_stb, stretching, bus_free;
  logic [8:0]  obs;
  int          n_chk;
  int          n_fail;
  bit          done;

  localparam logic [8:0] IDLE_V = 9'b0_0000_0001;

  i2c_scl_timer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_high_word (cfg_high_word),
    .cfg_low_word  (cfg_low_word),
    .cfg_bus_word  (cfg_bus_word),
    .cmd_start     (cmd_start),
    .cmd_stop      (cmd_stop),
    .stretch_en    (stretch_en),
    .scl_in        (scl_in),
    .scl_oe        (scl_oe),
    .start_stb     (start_stb),
    .fall_stb      (fall_stb),
    .launch_stb    (launch_stb),
    .rise_stb      (rise_stb),
    .sample_stb    (sample_stb),
    .stop_stb      (stop_stb),
    .stretching    (stretching),
    .bus_free      (bus_free)
  );

  assign obs = {scl_oe, start_stb, fall_stb, launch_stb, rise_stb,
                sample_stb, stop_stb, stretching, bus_free};

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
    end
  endtask

  // phase kinds: 0 hold, 1 low, 2 high, 3 stop low, 4 stop setup, 5 bus-free
  task automatic run_vec(input vec_t v);
    int nph;
    logic [5:0] pad;
    pad = v.junk ? 6'h3F : 6'h00;
    cfg_high_word = {pad, v.hi, pad, v.ro};
    cfg_low_word  = {pad, v.lo, pad, v.to};
    cfg_bus_word  = {pad, v.bfree, pad, v.lead};
    stretch_en    = v.st_en;
    scl_in        = 1'b1;
    if (v.idle_stop) begin
      // R10: a stop while idle must not cut the coming transfer short
      for (int k = 0; k < 2; k++) begin
        cmd_stop = 1'b1;
        #1 chk("R10 idle stop", obs, IDLE_V);
        @(negedge clk);
      end
      cmd_stop = 1'b0;
    end
    cmd_start = 1'b1;
    #1 chk("R3 before start", obs, IDLE_V);
    @(negedge clk);
    cmd_start = 1'b0;
    nph = 2 * int'(v.nbits) + 4;
    for (int p = 0; p < nph; p++) begin
      int kind;
      int plen;
      int nb2;
      string tag;
      nb2 = 2 * int'(v.nbits);
      if (p == 0)           kind = 0;
      else if (p <= nb2)    kind = (p % 2 == 1) ? 1 : 2;
      else if (p == nb2 + 1) kind = 3;
      else if (p == nb2 + 2) kind = 4;
      else                  kind = 5;
      case (kind)
        0:       begin plen = (v.lead == 0) ? 1 : int'(v.lead); tag = "R3"; end
        1:       begin plen = int'(v.lo) + 2; tag = "R4"; end
        2:       begin plen = int'(v.hi) + 7; tag = "R5"; end
        3:       begin plen = int'(v.lo) + 2; tag = "R7"; end
        4:       begin plen = int'(v.hi) + 7; tag = "R7"; end
        default: begin plen = (v.bfree == 0) ? 1 : int'(v.bfree); tag = "R8"; end
      endcase
      if (v.junk) tag = {tag, "/R2"};
      if (p == 2 && v.st_en) begin
        // R9: held high phase, count frozen, no strobe
        for (int s = 0; s < int'(v.st_cyc); s++) begin
          scl_in   = 1'b0;
          cmd_stop = 1'b0;
          #1 chk("R9 stretch", obs, 9'b0_0000_0010);
          @(negedge clk);
        end
      end
      for (int c = 0; c < plen; c++) begin
        logic [8:0] e;
        bit lowk, highk;
        lowk  = (kind == 1) || (kind == 3);
        highk = (kind == 2) || (kind == 4);
        scl_in    = (p == 2 && !v.st_en && c < int'(v.st_cyc)) ? 1'b0 : 1'b1;
        cmd_stop  = (p == nb2 && c == 0);
        cmd_start = v.busy_start && (p == 1) && (c == 0);
        e = {lowk,
             (kind == 0) && (c == 0),
             lowk && (c == 0),
             lowk && (c == int'(v.to)),
             highk && (c == 0),
             (kind == 2) && (c == int'(v.ro)),
             (kind == 4) && (c == plen - 1),
             1'b0,
             1'b0};
        #1 chk((p == 2 && !v.st_en && v.st_cyc != 0) ? {tag, "/R9"} : tag, obs, e);
        @(negedge clk);
      end
    end
    cmd_stop  = 1'b0;
    cmd_start = 1'b0;
    scl_in    = 1'b1;
    #1 chk("R8 free again", obs, IDLE_V);
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    cmd_start = 1'b0; cmd_stop = 1'b0; stretch_en = 1'b0; scl_in = 1'b1;
    cfg_high_word = '0; cfg_low_word = '0; cfg_bus_word = '0;
    repeat (3) @(negedge clk);
    #1 chk("R1 in reset", obs, IDLE_V);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R1 after reset", obs, IDLE_V);
    @(negedge clk);

    // R6 and the phase rules, one row per timing set
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R1: reset taken in the middle of a transfer returns to idle at once
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 mid-transfer reset", obs, IDLE_V);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R1 idle after reset", obs, IDLE_V);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule